// File: doc/BRIEF.md
# Floating-Point Status Register Unit

This unit keeps the 32-bit status word of a floating-point unit. Whenever the datapath finishes a floating-point instruction it raises a completion strobe together with four condition-code flags and an eight-bit exception vector. On that strobe the unit replaces the condition codes and the current-exception byte with the new values. In the same cycle it folds the new exception byte into a sticky accrued-exception byte. The accrued byte is not a plain copy of the exception byte. The invalid-operation bit collects three separate causes, and the underflow bit accrues only when the result was also inexact.

Software may overwrite the whole word at any time. Reserved positions always read back as zero, and a software write wins over a completion strobe in the same cycle. Each cycle the unit takes exactly one of three update kinds: HOLD (nothing changes), COMPLETE (datapath result merged) or SOFTWARE (the write data is loaded). COMPLETE is chosen on a strobe with no write, and SOFTWARE on any write. Integer and floating-point instructions may run at the same time, so a trapped instruction cannot be found from the stacked program counter. For that reason the unit also keeps an instruction-address register that captures the address of each completing floating-point instruction. A per-instruction flag tells it to skip instructions, such as register moves, that must leave the address unchanged.

Top module: `fpu_status_unit`

## Requirements
- R1: While reset (rst_n low) is applied, and in the first cycle after it, the status word and the instruction address both read zero.
- R2: One cycle after a completion strobe with no software write, status bits 27..24 hold the condition codes {negative, zero, infinity, NaN} and bits 15..8 hold the exception vector {unordered-branch, input NaN, operand error, overflow, underflow, divide-by-zero, inexact, input denormal}, with the first-named bit of each list at the top.
- R3: On a completion, accrued overflow (bit 6), divide-by-zero (bit 4) and inexact (bit 3) each become their old value ORed with exception overflow (bit 12), divide-by-zero (bit 10) and inexact (bit 9) respectively.
- R4: On a completion, accrued invalid-operation (bit 7) becomes its old value ORed with any of exception bits 15, 14 and 13.
- R5: On a completion, accrued underflow (bit 5) becomes its old value ORed with the AND of exception underflow (bit 11) and exception inexact (bit 9); underflow without inexact leaves it unchanged.
- R6: Accrued bits 7..3 never fall except through a software write or reset, including when a completion reports no exceptions.
- R7: A software write loads bits 27..24 and 15..3 from the write data; bits 31..28, 23..16 and 2..0 always read zero.
- R8: When a software write and a completion strobe fall in the same cycle, the status word takes the write data alone.
- R9: The instruction address loads the instruction address input one cycle after a completion strobe whose skip flag is low, and is unchanged in every other cycle.
- R10: In a cycle with neither a strobe nor a write, the status word is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| done_i | input | 1 | Floating-point instruction completion strobe |
| cc_i | input | 4 | Result condition codes {negative, zero, infinity, NaN} |
| exc_i | input | 8 | Exception vector of the completing instruction |
| addr_i | input | AW | Address of the completing instruction |
| skip_addr_i | input | 1 | Leave the instruction address unchanged for this completion |
| sw_wr_i | input | 1 | Software write of the status word |
| sw_wdata_i | input | 32 | Software write data |
| status_o | output | 32 | Status word |
| iaddr_o | output | AW | Address of the last recorded floating-point instruction |

## Verification
The assertions check every cycle that reserved positions stay zero, that accrued bits never fall without a write, that the HOLD, COMPLETE and SOFTWARE kinds each produce the word their inputs call for, and that the address register loads or holds as the strobe and skip flag dictate. Only the bench's scenarios show the particular combining cases. These are underflow with and without inexact, each of the three invalid-operation causes on its own, and a write colliding with a strobe, checked against independently computed values across long random sequences and a reset in mid-run.

// File: rtl/fpsr_pkg.sv
package fpsr_pkg;

    localparam int WORD_W  = 32;
    localparam int CC_W    = 4;
    localparam int EXC_W   = 8;
    localparam int ACC_W   = 5;
    localparam int CC_LSB  = 24;
    localparam int EXC_LSB = 8;
    localparam int ACC_LSB = 3;
    localparam int CC_MSB  = CC_LSB + CC_W - 1;
    localparam int EXC_MSB = EXC_LSB + EXC_W - 1;
    localparam int ACC_MSB = ACC_LSB + ACC_W - 1;

    typedef struct packed {
        logic neg;
        logic zero;
        logic inf;
        logic nan;
    } cc_t;

    typedef struct packed {
        logic bsun;
        logic inan;
        logic operr;
        logic ovfl;
        logic unfl;
        logic dz;
        logic inex;
        logic ide;
    } exc_t;

    typedef struct packed {
        logic iop;
        logic ovfl;
        logic unfl;
        logic dz;
        logic inex;
    } acc_t;

    typedef enum logic [1:0] {
        UPD_HOLD     = 2'd0,
        UPD_COMPLETE = 2'd1,
        UPD_SOFTWARE = 2'd2
    } upd_e;

    function automatic logic [WORD_W-1:0] pack_word(cc_t c, exc_t e, acc_t a);
        logic [WORD_W-1:0] w;
        w = '0;
        w[CC_MSB:CC_LSB]   = c;
        w[EXC_MSB:EXC_LSB] = e;
        w[ACC_MSB:ACC_LSB] = a;
        return w;
    endfunction

endpackage

// File: rtl/fpsr_accrue.sv
module fpsr_accrue
    import fpsr_pkg::*;
(
    input  acc_t cur_i,
    input  exc_t exc_i,
    output acc_t nxt_o
);

    always_comb begin
        nxt_o.iop  = cur_i.iop  | exc_i.bsun | exc_i.inan | exc_i.operr;
        nxt_o.ovfl = cur_i.ovfl | exc_i.ovfl;
        nxt_o.unfl = cur_i.unfl | (exc_i.unfl & exc_i.inex);
        nxt_o.dz   = cur_i.dz   | exc_i.dz;
        nxt_o.inex = cur_i.inex | exc_i.inex;
    end

endmodule

// File: rtl/fpsr_word.sv
module fpsr_word
    import fpsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  upd_e              upd_i,
    input  cc_t               cc_i,
    input  exc_t              exc_i,
    input  logic [WORD_W-1:0] wdata_i,
    output logic [WORD_W-1:0] word_o
);

    cc_t  cc_q,  cc_d;
    exc_t exc_q, exc_d;
    acc_t acc_q, acc_d;
    acc_t acc_merged;

    fpsr_accrue u_accrue (
        .cur_i (acc_q),
        .exc_i (exc_i),
        .nxt_o (acc_merged)
    );

    always_comb begin
        cc_d  = cc_q;
        exc_d = exc_q;
        acc_d = acc_q;
        unique case (upd_i)
            UPD_HOLD: begin
            end
            UPD_COMPLETE: begin
                cc_d  = cc_i;
                exc_d = exc_i;
                acc_d = acc_merged;
            end
            UPD_SOFTWARE: begin
                cc_d  = cc_t'(wdata_i[CC_MSB:CC_LSB]);
                exc_d = exc_t'(wdata_i[EXC_MSB:EXC_LSB]);
                acc_d = acc_t'(wdata_i[ACC_MSB:ACC_LSB]);
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cc_q  <= '0;
            exc_q <= '0;
            acc_q <= '0;
        end else begin
            cc_q  <= cc_d;
            exc_q <= exc_d;
            acc_q <= acc_d;
        end
    end

    assign word_o = pack_word(cc_q, exc_q, acc_q);

endmodule

// File: rtl/fpia_reg.sv
module fpia_reg #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [AW-1:0] addr_i,
    output logic [AW-1:0] addr_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_o <= '0;
        end else if (load_i) begin
            addr_o <= addr_i;
        end
    end

endmodule

// File: rtl/fpu_status_unit.sv
module fpu_status_unit
    import fpsr_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          done_i,
    input  logic [3:0]    cc_i,
    input  logic [7:0]    exc_i,
    input  logic [AW-1:0] addr_i,
    input  logic          skip_addr_i,
    input  logic          sw_wr_i,
    input  logic [31:0]   sw_wdata_i,
    output logic [31:0]   status_o,
    output logic [AW-1:0] iaddr_o
);

    upd_e upd;
    logic addr_load;

    always_comb begin
        if (sw_wr_i) begin
            upd = UPD_SOFTWARE;
        end else if (done_i) begin
            upd = UPD_COMPLETE;
        end else begin
            upd = UPD_HOLD;
        end
    end

    assign addr_load = done_i & ~skip_addr_i;

    fpsr_word u_word (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd_i   (upd),
        .cc_i    (cc_t'(cc_i)),
        .exc_i   (exc_t'(exc_i)),
        .wdata_i (sw_wdata_i),
        .word_o  (status_o)
    );

    fpia_reg #(.AW(AW)) u_iar (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (addr_load),
        .addr_i (addr_i),
        .addr_o (iaddr_o)
    );

endmodule

// File: rtl/fpu_status_unit_chk.sv
module fpu_status_unit_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          done_i,
    input logic [3:0]    cc_i,
    input logic [7:0]    exc_i,
    input logic [AW-1:0] addr_i,
    input logic          skip_addr_i,
    input logic          sw_wr_i,
    input logic [31:0]   sw_wdata_i,
    input logic [31:0]   status_o,
    input logic [AW-1:0] iaddr_o
);

    localparam logic [31:0] LIVE = 32'h0F00_FFF8;

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (status_o == 32'h0 && iaddr_o == '0));

    assert_complete_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && !sw_wr_i) |=> (status_o[15:8] == $past(exc_i) && status_o[27:24] == $past(cc_i)));

    assert_iop_merge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && !sw_wr_i && (exc_i[7:5] != 3'b000)) |=> status_o[7]);

    assert_unfl_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && !sw_wr_i && !status_o[5] && !exc_i[1]) |=> !status_o[5]);

    assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_wr_i |=> ((status_o[7:3] & $past(status_o[7:3])) == $past(status_o[7:3])));

    assert_reserved_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o & ~LIVE) == 32'h0);

    assert_write_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sw_wr_i |=> status_o == ($past(sw_wdata_i) & LIVE));

    assert_addr_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && !skip_addr_i) |=> iaddr_o == $past(addr_i));

    assert_addr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!done_i || skip_addr_i) |=> $stable(iaddr_o));

    assert_idle_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!done_i && !sw_wr_i) |=> $stable(status_o));

endmodule

bind fpu_status_unit fpu_status_unit_chk #(.AW(AW)) u_chk (.*);

// File: tb/fpu_status_unit_bench.sv
`timescale 1ns/1ps
module fpu_status_unit_bench;

    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          done_i = 1'b0;
    logic [3:0]    cc_i = '0;
    logic [7:0]    exc_i = '0;
    logic [AW-1:0] addr_i = '0;
    logic          skip_addr_i = 1'b0;
    logic          sw_wr_i = 1'b0;
    logic [31:0]   sw_wdata_i = '0;
    logic [31:0]   status_o;
    logic [AW-1:0] iaddr_o;

    int unsigned total = 0;
    int unsigned bad = 0;
    int unsigned cycles = 0;
    bit          finished = 1'b0;

    logic [3:0]    m_cc;
    logic [7:0]    m_exc;
    logic [4:0]    m_acc;
    logic [AW-1:0] m_addr;

    always #4 clk = ~clk;

    fpu_status_unit #(.AW(AW)) u_fpu_status_unit (
        .clk         (clk),
        .rst_n       (rst_n),
        .done_i      (done_i),
        .cc_i        (cc_i),
        .exc_i       (exc_i),
        .addr_i      (addr_i),
        .skip_addr_i (skip_addr_i),
        .sw_wr_i     (sw_wr_i),
        .sw_wdata_i  (sw_wdata_i),
        .status_o    (status_o),
        .iaddr_o     (iaddr_o)
    );

    function automatic logic [31:0] exp_word(logic [3:0] c, logic [7:0] e, logic [4:0] a);
        return {4'h0, c, 8'h00, e, a, 3'b000};
    endfunction

    function automatic logic [4:0] merge(logic [4:0] a, logic [7:0] e);
        logic [4:0] n;
        n[4] = a[4] | e[7] | e[6] | e[5];
        n[3] = a[3] | e[4];
        n[2] = a[2] | (e[3] & e[1]);
        n[1] = a[1] | e[2];
        n[0] = a[0] | e[1];
        return n;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_cc = '0; m_exc = '0; m_acc = '0; m_addr = '0;
    endtask

    task automatic step(logic d, logic [3:0] c, logic [7:0] e, logic [AW-1:0] a,
                        logic h, logic w, logic [31:0] wd, string tag);
        done_i = d; cc_i = c; exc_i = e; addr_i = a; skip_addr_i = h;
        sw_wr_i = w; sw_wdata_i = wd;
        @(posedge clk);
        if (w) begin
            m_cc = wd[27:24]; m_exc = wd[15:8]; m_acc = wd[7:3];
        end else if (d) begin
            m_cc = c; m_exc = e; m_acc = merge(m_acc, e);
        end
        if (d && !h) m_addr = a;
        @(negedge clk);
        done_i = 1'b0; sw_wr_i = 1'b0;
        chk(tag, status_o, exp_word(m_cc, m_exc, m_acc));
        chk("R9", iaddr_o, m_addr);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000 && !finished) begin
                bad++;
                $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cycles);
                $display("test done: total=%0d bad=%0d", total + 1, bad);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd20240517));
        model_reset();
        repeat (3) @(negedge clk);
        chk("R1", status_o, 32'h0);
        chk("R1", iaddr_o, '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", status_o, 32'h0);

        step(1, 4'b1010, 8'b0001_0010, 32'h0000_1000, 0, 0, 0, "R2");
        step(0, 4'b0000, 8'h00, 32'h0, 0, 0, 0, "R10");
        step(1, 4'b0101, 8'b0000_1000, 32'h0000_1004, 0, 0, 0, "R5");
        step(1, 4'b0001, 8'b0000_1010, 32'h0000_1008, 0, 0, 0, "R5");
        step(1, 4'b0000, 8'b0000_0100, 32'h0000_100C, 0, 0, 0, "R3");
        step(1, 4'b0000, 8'h00, 32'h0000_1010, 0, 0, 0, "R6");
        step(0, 4'h0, 8'h00, 32'h0, 0, 1, 32'h0000_0000, "R7");
        step(1, 4'h0, 8'b1000_0000, 32'h0000_1014, 0, 0, 0, "R4");
        step(0, 4'h0, 8'h00, 32'h0, 0, 1, 32'h0000_0000, "R7");
        step(1, 4'h0, 8'b0100_0000, 32'h0000_1018, 0, 0, 0, "R4");
        step(0, 4'h0, 8'h00, 32'h0, 0, 1, 32'h0000_0000, "R7");
        step(1, 4'h0, 8'b0010_0000, 32'h0000_101C, 1, 0, 0, "R4");
        step(1, 4'h0, 8'b0000_0001, 32'h0000_1020, 1, 0, 0, "R9");
        step(0, 4'h0, 8'h00, 32'h0, 0, 1, 32'hFFFF_FFFF, "R7");
        step(1, 4'h3, 8'h11, 32'h0000_2000, 0, 1, 32'h5A5A_5A5A, "R8");
        step(1, 4'hC, 8'h00, 32'h0000_2004, 0, 0, 0, "R6");

        for (int i = 0; i < 600; i++) begin
            logic          d, h, w;
            logic [3:0]    c;
            logic [7:0]    e;
            logic [AW-1:0] a;
            logic [31:0]   wd;
            d  = ($urandom % 3) != 0;
            h  = ($urandom % 4) == 0;
            w  = ($urandom % 10) == 0;
            c  = 4'($urandom);
            e  = ($urandom % 3 == 0) ? 8'h00 : 8'($urandom);
            a  = AW'($urandom);
            wd = ($urandom % 2 == 0) ? 32'h0 : $urandom;
            step(d, c, e, a, h, w, wd, w ? "R8" : (d ? "R3" : "R10"));
        end

        rst_n = 1'b0;
        model_reset();
        @(negedge clk);
        chk("R1", status_o, 32'h0);
        chk("R1", iaddr_o, '0);
        rst_n = 1'b1;
        @(negedge clk);
        step(1, 4'h8, 8'b1111_1111, 32'h0000_3000, 0, 0, 0, "R4");

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule